// File: doc/BRIEF.md
# Eight-Bit Multicycle Register Processor

This block is a small 8-bit processor. It runs a ten-instruction program held in a byte-wide read-only program memory outside the block. The block drives the memory address from its address register and takes the byte back combinationally on the same cycle. The processor has four general registers, a program counter, an address register, an instruction register and three latched condition flags: carry, zero and sign. An 8-bit switch port supplies data to the input instruction. An 8-bit LED register holds whatever the output instruction last wrote.

Sequencing is done by a hardwired multicycle state machine. A free-running 2-bit phase counter splits every machine step into four clock phases. All architectural state changes on the last phase of a step. A step sequence fetches each instruction, decodes it and, for the two-byte forms, fetches one operand byte. The instruction byte holds a 4-bit opcode and two 2-bit register selects. Compare and test set flags. Two conditional jumps then read those flags.

Top module: `cpu8_core`

## Requirements
- R1: While `rstN` is low, `leds` reads 00h and `romAddr` reads 00h. The first instruction after reset is fetched from address 00h. All four registers and all three flags start at zero.
- R2: The opcode sits in instruction bits 7..4. Bits 3..2 select the source register and bits 1..0 select the destination register. Select code n picks register Rn (00=R0, 01=R1, 10=R2, 11=R3).
- R3: Each step lasts four clocks, and state changes only on the fourth clock of a step. A one-byte instruction takes 3 steps (12 clocks), made up of address, instruction load and execute. A two-byte instruction takes 5 steps (20 clocks). `romAddr` shows the instruction address from the end of the first step.
- R4: Opcode 0000 (IN) copies `switches` into Rd. Opcode 0010 copies Rs into Rd. Opcode 0100 (INC) writes Rd+1 mod 256 into Rd. Opcode 0011 (OUT) loads Rs into `leds`, and nothing else changes `leds`.
- R5: Opcode 0001 (MOVI) writes the byte that follows the opcode into Rd. Execution resumes two bytes after the opcode.
- R6: Opcode 0110 (CMP) compares Rs with Rd as unsigned numbers. It sets carry when Rs<Rd and zero when they are equal; otherwise both are clear. It writes no register and leaves sign unchanged.
- R7: Opcode 0111 (TEST) sets the sign flag to bit 7 of Rd and leaves carry and zero unchanged.
- R8: Opcode 1001 (JB) loads its second byte into the PC when carry is 1 and zero is 0. Otherwise it continues after the address byte.
- R9: Opcode 1000 (JS) loads its second byte into the PC when the sign flag is 1. Otherwise it continues after the address byte.
- R10: Opcode 0101 (JMP) always loads its second byte into the PC.
- R11: Only CMP and TEST change flags. All other opcodes leave all three flags as they were.
- R12: Opcodes 1010 to 1111 are one-byte instructions that change nothing but the PC.
- R13: A loop of IN, TEST, JS, CMP, JB, OUT and register move keeps `leds` equal to the largest non-negative value read so far, starting from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| switches | input | 8 | Data read by the input instruction |
| romData | input | 8 | Byte returned by the program memory for `romAddr` |
| romAddr | output | 8 | Program memory address (address register) |
| leds | output | 8 | Output register written by the output instruction |

## Verification
A two-byte jump sends the PC to a new target on the same edge where the fetch sequence would otherwise have incremented it. The operand address step and the jump load are also adjacent steps that both write the PC. Random programs put jumps at every offset, including address FFh where the operand wraps to 00h. The bench checks `romAddr` on the fourth clock of the next instruction's address step against a bench model of the PC. Compare-then-jump pairs with equal, smaller and larger operands check that the flags from one instruction decide the branch of the next.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int NREG    = 4;
  localparam int SEL_W   = $clog2(NREG);
  localparam int OP_W    = 4;
  localparam int PHASES  = 4;
  localparam int PH_W    = $clog2(PHASES);

  typedef enum logic [OP_W-1:0] {
    OP_IN   = 4'h0,
    OP_MOVI = 4'h1,
    OP_MOVR = 4'h2,
    OP_OUT  = 4'h3,
    OP_INC  = 4'h4,
    OP_JMP  = 4'h5,
    OP_CMP  = 4'h6,
    OP_TEST = 4'h7,
    OP_JS   = 4'h8,
    OP_JB   = 4'h9
  } opcode_e;

  typedef enum logic [1:0] {
    WS_SWITCH,
    WS_COPY,
    WS_INC,
    WS_ROM
  } wsrc_e;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_IR,
    ST_EXEC,
    ST_OPND_ADDR,
    ST_OPND_DATA
  } step_e;

  typedef struct packed {
    logic  fetchAddr;
    logic  irLoad;
    logic  regWe;
    wsrc_e wsrc;
    logic  ledWe;
    logic  cmpWe;
    logic  testWe;
    logic  jumpLoad;
  } strobe_t;

  function automatic logic isTwoByte(input logic [OP_W-1:0] op);
    return (op == OP_MOVI) || (op == OP_JMP) || (op == OP_JS) || (op == OP_JB);
  endfunction
endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] srcVal,
  input  logic [W-1:0] dstVal,
  output logic [W-1:0] incVal,
  output logic         lessThan,
  output logic         equal,
  output logic         negative
);
  logic [W:0] diff;

  always_comb begin
    diff     = {1'b0, srcVal} - {1'b0, dstVal};
    lessThan = diff[W];
    equal    = (diff[W-1:0] == '0);
    incVal   = dstVal + {{(W-1){1'b0}}, 1'b1};
    negative = dstVal[W-1];
  end
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OP_W-1:0]     opBits,
  input  logic                flagC,
  input  logic                flagZ,
  input  logic                flagS,
  output logic [PH_W-1:0]     phase,
  output strobe_t             ctl
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  step_e   step;
  step_e   nextStep;
  logic    tick;
  opcode_e op;
  strobe_t raw;

  assign tick = (phase == LAST_PH);
  assign op   = opcode_e'(opBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      step  <= ST_FETCH_ADDR;
    end else begin
      phase <= phase + 1'b1;
      if (tick) step <= nextStep;
    end
  end

  always_comb begin
    case (step)
      ST_FETCH_ADDR: nextStep = ST_FETCH_IR;
      ST_FETCH_IR:   nextStep = ST_EXEC;
      ST_EXEC:       nextStep = isTwoByte(opBits) ? ST_OPND_ADDR : ST_FETCH_ADDR;
      ST_OPND_ADDR:  nextStep = ST_OPND_DATA;
      default:       nextStep = ST_FETCH_ADDR;
    endcase
  end

  always_comb begin
    raw = '0;
    raw.wsrc = WS_SWITCH;
    case (step)
      ST_FETCH_ADDR, ST_OPND_ADDR: raw.fetchAddr = 1'b1;
      ST_FETCH_IR:                 raw.irLoad = 1'b1;
      ST_EXEC: begin
        case (op)
          OP_IN:   begin raw.regWe = 1'b1; raw.wsrc = WS_SWITCH; end
          OP_MOVR: begin raw.regWe = 1'b1; raw.wsrc = WS_COPY;   end
          OP_INC:  begin raw.regWe = 1'b1; raw.wsrc = WS_INC;    end
          OP_OUT:  raw.ledWe  = 1'b1;
          OP_CMP:  raw.cmpWe  = 1'b1;
          OP_TEST: raw.testWe = 1'b1;
          default: ;
        endcase
      end
      ST_OPND_DATA: begin
        case (op)
          OP_MOVI: begin raw.regWe = 1'b1; raw.wsrc = WS_ROM; end
          OP_JMP:  raw.jumpLoad = 1'b1;
          OP_JS:   raw.jumpLoad = flagS;
          OP_JB:   raw.jumpLoad = flagC & ~flagZ;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl = raw;
    if (!tick) begin
      ctl.fetchAddr = 1'b0;
      ctl.irLoad    = 1'b0;
      ctl.regWe     = 1'b0;
      ctl.ledWe     = 1'b0;
      ctl.cmpWe     = 1'b0;
      ctl.testWe    = 1'b0;
      ctl.jumpLoad  = 1'b0;
    end
  end
endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
  import cpu8_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            ctl,
  input  logic [DATA_W-1:0]  switches,
  input  logic [DATA_W-1:0]  romData,
  output logic [ADDR_W-1:0]  romAddr,
  output logic [DATA_W-1:0]  leds,
  output logic [OP_W-1:0]    opBits,
  output logic               flagC,
  output logic               flagZ,
  output logic               flagS,
  output logic [ADDR_W-1:0]  pcVal
);
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ar;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] regFile [NREG];
  logic [SEL_W-1:0]  srcSel;
  logic [SEL_W-1:0]  dstSel;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] dstVal;
  logic [DATA_W-1:0] incVal;
  logic [DATA_W-1:0] wData;
  logic              lessThan;
  logic              equal;
  logic              negative;

  assign opBits  = ir[DATA_W-1 -: OP_W];
  assign srcSel  = ir[2*SEL_W-1 -: SEL_W];
  assign dstSel  = ir[SEL_W-1:0];
  assign srcVal  = regFile[srcSel];
  assign dstVal  = regFile[dstSel];
  assign romAddr = ar;
  assign pcVal   = pc;

  cpu8_alu #(.W(DATA_W)) alu_i (
    .srcVal   (srcVal),
    .dstVal   (dstVal),
    .incVal   (incVal),
    .lessThan (lessThan),
    .equal    (equal),
    .negative (negative)
  );

  always_comb begin
    case (ctl.wsrc)
      WS_SWITCH: wData = switches;
      WS_COPY:   wData = srcVal;
      WS_INC:    wData = incVal;
      default:   wData = romData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
      ar <= '0;
    end else if (ctl.fetchAddr) begin
      ar <= pc;
      pc <= pc + 1'b1;
    end else if (ctl.jumpLoad) begin
      pc <= romData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ir <= '0;
    else if (ctl.irLoad) ir <= romData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          leds <= '0;
    else if (ctl.ledWe) leds <= srcVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC <= 1'b0;
      flagZ <= 1'b0;
      flagS <= 1'b0;
    end else if (ctl.cmpWe) begin
      flagC <= lessThan;
      flagZ <= equal;
    end else if (ctl.testWe) begin
      flagS <= negative;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (ctl.regWe && (dstSel == SEL_W'(g)))
        regFile[g] <= wData;
    end
  end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] switches,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] leds
);
  strobe_t           ctl;
  logic [PH_W-1:0]   phase;
  logic [OP_W-1:0]   opBits;
  logic              flagC;
  logic              flagZ;
  logic              flagS;
  logic [ADDR_W-1:0] pcVal;

  cpu8_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .opBits (opBits),
    .flagC  (flagC),
    .flagZ  (flagZ),
    .flagS  (flagS),
    .phase  (phase),
    .ctl    (ctl)
  );

  cpu8_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .switches (switches),
    .romData  (romData),
    .romAddr  (romAddr),
    .leds     (leds),
    .opBits   (opBits),
    .flagC    (flagC),
    .flagZ    (flagZ),
    .flagS    (flagS),
    .pcVal    (pcVal)
  );
endmodule

// File: rtl/cpu8_checker.sv
module cpu8_checker
  import cpu8_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           ctl,
  input logic [PH_W-1:0]   phase,
  input logic              flagC,
  input logic              flagZ,
  input logic              flagS,
  input logic [ADDR_W-1:0] pcVal,
  input logic [ADDR_W-1:0] romAddr,
  input logic [DATA_W-1:0] leds
);
  p_phase_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (phase == PH_W'($past(phase) + 1'b1)));

  p_addr_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_W'(PHASES - 1)) |=> $stable(romAddr));

  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.fetchAddr || ctl.jumpLoad) |=> $stable(pcVal));

  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.fetchAddr, ctl.irLoad, ctl.regWe, ctl.ledWe,
              ctl.cmpWe, ctl.testWe, ctl.jumpLoad}));

  p_led_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ledWe |=> $stable(leds));

  p_cmp_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmpWe |=> !(flagC && flagZ));

  p_sign_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmpWe |=> $stable(flagS));

  p_cz_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.testWe |=> ($stable(flagC) && $stable(flagZ)));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.cmpWe || ctl.testWe) |=> $stable({flagC, flagZ, flagS}));
endmodule

bind cpu8_core cpu8_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .ctl     (ctl),
  .phase   (phase),
  .flagC   (flagC),
  .flagZ   (flagZ),
  .flagS   (flagS),
  .pcVal   (pcVal),
  .romAddr (romAddr),
  .leds    (leds)
);

// File: tb/cpu8_core_tb_top.sv
`timescale 1ns/1ps
module cpu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] switches = 8'h00;
  logic [7:0] romAddr;
  logic [7:0] romData;
  logic [7:0] leds;
  logic [7:0] rom [256];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mReg [4];
  logic [7:0] mPc, mLed;
  logic       mC, mZ, mS;
  string      lastTag;
  bit         trackMax;
  logic [7:0] maxSeen;

  always #5 clk = ~clk;

  assign romData = rom[romAddr];

  cpu8_core dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .switches (switches),
    .romData  (romData),
    .romAddr  (romAddr),
    .leds     (leds)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic bit twoByteOp(input logic [3:0] op);
    return op == 4'h1 || op == 4'h5 || op == 4'h8 || op == 4'h9;
  endfunction

  function automatic logic [7:0] largerNonNeg(input logic [7:0] cur, input logic [7:0] v);
    return (!v[7] && v > cur) ? v : cur;
  endfunction

  task automatic clearRom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(leds == 8'h00, "R1 leds in reset", leds, 8'h00);
    check(romAddr == 8'h00, "R1 romAddr in reset", romAddr, 8'h00);
    for (int i = 0; i < 4; i++) mReg[i] = 8'h00;
    mPc = 8'h00; mLed = 8'h00; mC = 0; mZ = 0; mS = 0;
    lastTag = "R1 first fetch";
    maxSeen = 8'h00;
    rstN = 1'b1;
  endtask

  task automatic runInstr(input logic [7:0] sw);
    logic [7:0] ins, opnd, prevLed, a1;
    logic [3:0] op;
    logic [1:0] s, d;
    int steps;
    switches = sw;
    ins = rom[mPc];
    op = ins[7:4]; s = ins[3:2]; d = ins[1:0];
    a1 = mPc + 8'd1;
    opnd = rom[a1];
    prevLed = mLed;
    steps = twoByteOp(op) ? 5 : 3;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(romAddr == mPc, lastTag, romAddr, mPc);
    mPc = mPc + (twoByteOp(op) ? 8'd2 : 8'd1);
    case (op)
      4'h0: begin mReg[d] = sw; if (trackMax) maxSeen = largerNonNeg(maxSeen, sw); end
      4'h1: mReg[d] = opnd;
      4'h2: mReg[d] = mReg[s];
      4'h3: mLed = mReg[s];
      4'h4: mReg[d] = mReg[d] + 8'd1;
      4'h5: mPc = opnd;
      4'h6: begin mC = mReg[s] < mReg[d]; mZ = mReg[s] == mReg[d]; end
      4'h7: mS = mReg[d][7];
      4'h8: if (mS) mPc = opnd;
      4'h9: if (mC && !mZ) mPc = opnd;
      default: ;
    endcase
    if (op == 4'h3) begin
      repeat (4*(steps-1)-1) @(posedge clk);
      @(negedge clk);
      check(leds == prevLed, "R3 leds one clock early", leds, prevLed);
      @(posedge clk);
      @(negedge clk);
      check(leds == mLed, "R2 R4 OUT", leds, mLed);
      if (trackMax) check(leds == maxSeen, "R13 running max", leds, maxSeen);
    end else begin
      repeat (4*(steps-1)) @(posedge clk);
      @(negedge clk);
      check(leds == mLed, "R4 R5 leds unchanged", leds, mLed);
    end
    case (op)
      4'h1: lastTag = "R5 MOVI next fetch";
      4'h5: lastTag = "R10 JMP target";
      4'h8: lastTag = "R7 R9 R11 JS";
      4'h9: lastTag = "R6 R8 R11 JB";
      4'ha, 4'hb, 4'hc, 4'hd, 4'he, 4'hf: lastTag = "R12 undefined opcode";
      default: lastTag = "R2 R3 next fetch";
    endcase
  endtask

  function automatic logic [7:0] cornerByte();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h7f;
      2: return 8'h80;
      3: return 8'hff;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    trackMax = 0;

    // Directed: flags and branches
    clearRom();
    rom[8'h00] = 8'h10; rom[8'h01] = 8'h05;
    rom[8'h02] = 8'h11; rom[8'h03] = 8'h05;
    rom[8'h04] = 8'h61;
    rom[8'h05] = 8'h90; rom[8'h06] = 8'h20;
    rom[8'h07] = 8'h12; rom[8'h08] = 8'h80;
    rom[8'h09] = 8'h72;
    rom[8'h0a] = 8'h40;
    rom[8'h0b] = 8'h80; rom[8'h0c] = 8'h10;
    rom[8'h10] = 8'h64;
    rom[8'h11] = 8'h90; rom[8'h12] = 8'h18;
    rom[8'h18] = 8'h30;
    rom[8'h19] = 8'h23;
    rom[8'h1a] = 8'h3c;
    rom[8'h1b] = 8'hf5;
    rom[8'h1c] = 8'h50; rom[8'h1d] = 8'h1c;
    doReset();
    for (int i = 0; i < 16; i++) runInstr(8'h00);
    check(leds == 8'h06, "R4 INC then OUT value", leds, 8'h06);

    // Directed: largest non-negative value loop
    clearRom();
    rom[8'h00] = 8'h00;
    rom[8'h01] = 8'h70;
    rom[8'h02] = 8'h80; rom[8'h03] = 8'h07;
    rom[8'h04] = 8'h64;
    rom[8'h05] = 8'h90; rom[8'h06] = 8'h0a;
    rom[8'h07] = 8'h34;
    rom[8'h08] = 8'h50; rom[8'h09] = 8'h00;
    rom[8'h0a] = 8'h21;
    rom[8'h0b] = 8'h50; rom[8'h0c] = 8'h07;
    doReset();
    trackMax = 1;
    begin
      logic [7:0] seq [12];
      int k;
      seq = '{8'h10, 8'h90, 8'h7f, 8'h00, 8'h80, 8'h05, 8'hff, 8'h7e,
              8'h30, 8'h81, 8'h7f, 8'h01};
      k = 0;
      for (int n = 0; n < 90; n++) begin
        logic [7:0] v;
        v = seq[k % 12];
        if (rom[mPc][7:4] == 4'h0) k++;
        runInstr(v);
      end
      for (int n = 0; n < 120; n++) runInstr(cornerByte());
    end
    trackMax = 0;

    // Random programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) rom[i] = cornerByte();
      for (int i = 0; i < 256; i += 7) rom[i] = {4'h3, 4'($urandom)};
      doReset();
      for (int n = 0; n < 300; n++) runInstr(cornerByte());
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule